// File: doc/BRIEF.md
# Two-Channel Daisy-Chain Interrupt Requester

This block is the peripheral side of a vectored interrupt scheme in which devices sit on a serial grant chain. It has two request channels, A and B. Each channel has its own enable bit. A rising edge on an enabled channel's request input sets that channel's pending latch. While either latch is set, the block raises its bus request.

When the grant arrives on the chain input, the block does one of two things. If it holds a pending request, it keeps the grant. It then drives an interrupt vector built from jumper inputs, together with a reply strobe, and clears the latch of the channel it served. Channel A is served before channel B. If nothing is pending, the block passes the grant on to the next device on the chain output.

The two enable bits are written through a simple strobe. They are visible on a status output, so that they can be read back as part of a control/status register.

Top module: `irq_chain_requester`

## Requirements
- R1: A rising edge on `req_a` or `req_b` while that channel's enable bit is 0 leaves no request: `bus_req` stays 0.
- R2: A 0-to-1 change on an enabled channel's request input, sampled at a clock edge, sets that channel's pending latch. `bus_req` is then 1 one cycle later. A request input that is already high when the enable is set creates no request.
- R3: When both channels are pending at the moment the grant is taken, channel A is served first and channel B stays pending.
- R4: If the block holds a pending request when `grant_in` rises, it keeps the grant. One cycle later `vec_reply` is 1 and `grant_out` stays 0. Both hold until `grant_in` falls.
- R5: If nothing is pending when `grant_in` rises, `grant_out` is 1 one cycle later and `vec_reply` stays 0. This holds until `grant_in` falls.
- R6: A cycle with `en_wr`=1 loads `en_wdata` into the enables, with bit 0 for channel A and bit 1 for channel B. `en_status` shows them with the same bit positions from the next cycle on.
- R7: While `rst` is high, both enables, both pending latches, `bus_req`, `grant_out`, `vec_reply` and `vec_out` are cleared.
- R8: The vector is `{vec_jumper, 3'b000}` for channel A and `{vec_jumper, 3'b100}` for channel B. `vec_out` is 0 whenever `vec_reply` is 0.
- R9: Writing 0 to a channel's enable cancels that channel's pending request, so a grant that follows is passed down the chain.
- R10: `bus_req` stays 1 while any latch is pending, including after the request input falls. It drops in the cycle after the grant is taken if no other channel is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 2 | New enables: bit 0 for channel A, bit 1 for channel B |
| req_a | input | 1 | Channel A request, edge-sensitive |
| req_b | input | 1 | Channel B request, edge-sensitive |
| vec_jumper | input | VEC_W-3 | Fixed upper vector bits |
| grant_in | input | 1 | Grant arriving from the chain |
| bus_req | output | 1 | Interrupt request to the bus |
| grant_out | output | 1 | Grant forwarded down the chain |
| vec_reply | output | 1 | Reply strobe while the vector is valid |
| vec_out | output | VEC_W | Interrupt vector, 0 when not replying |
| en_status | output | 2 | Current enable bits |

## Verification
The bench builds the block with the default `VEC_W` of 9 and a jumper value of octal 12. With these values the two channel vectors are octal 120 and 124, so a wrong channel-select bit or a shifted jumper field shows up directly in the expected vectors.

The grant sequences cover several cases:
- both channels pending at once, which exercises priority and the partial drop of `bus_req`;
- a grant with nothing pending;
- a cancel by disabling a channel;
- a request held high across re-enabling;
- a reset while a request is pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_CH = 2;
  typedef enum logic [1:0] {
    GS_IDLE   = 2'd0,
    GS_TAKEN  = 2'd1,
    GS_PASSED = 2'd2
  } gnt_state_e;
endpackage

// File: rtl/irq_channel.sv
module irq_channel (
  input  logic clk,
  input  logic rst,
  input  logic en_we,
  input  logic en_d,
  input  logic req_in,
  input  logic take_clr,
  output logic enable,
  output logic pending
);
  logic req_q;
  logic req_edge;

  assign req_edge = req_in & ~req_q & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable  <= 1'b0;
      req_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_q <= req_in;
      if (en_we) enable <= en_d;
      // cancel by disable wins, then a fresh edge, then service clear
      if (en_we && !en_d)  pending <= 1'b0;
      else if (req_edge)   pending <= 1'b1;
      else if (take_clr)   pending <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_grant.sv
module irq_grant
  import irq_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_in,
  input  logic [N_CH-1:0]  pend,
  input  logic [VEC_W-4:0] jumper,
  output logic [N_CH-1:0]  take_clr,
  output logic             grant_out,
  output logic             vec_reply,
  output logic [VEC_W-1:0] vec_out
);
  gnt_state_e       state;
  logic [VEC_W-1:0] vec_q;
  logic             start;
  logic             take;
  logic             pick_b;

  assign start  = (state == GS_IDLE) && grant_in;
  assign take   = start && (|pend);
  assign pick_b = ~pend[0];

  always_comb begin
    take_clr = '0;
    if (take) begin
      if (pick_b) take_clr[1] = 1'b1;
      else        take_clr[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= GS_IDLE;
      vec_q <= '0;
    end else begin
      case (state)
        GS_IDLE: begin
          if (take) begin
            state <= GS_TAKEN;
            vec_q <= {jumper, pick_b, 2'b00};
          end else if (start) begin
            state <= GS_PASSED;
          end
        end
        default: begin
          if (!grant_in) begin
            state <= GS_IDLE;
            vec_q <= '0;
          end
        end
      endcase
    end
  end

  assign vec_reply = (state == GS_TAKEN);
  assign grant_out = (state == GS_PASSED);
  assign vec_out   = vec_q;
endmodule

// File: rtl/irq_chain_requester.sv
module irq_chain_requester
  import irq_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic [1:0]       en_wdata,
  input  logic             req_a,
  input  logic             req_b,
  input  logic [VEC_W-4:0] vec_jumper,
  input  logic             grant_in,
  output logic             bus_req,
  output logic             grant_out,
  output logic             vec_reply,
  output logic [VEC_W-1:0] vec_out,
  output logic [1:0]       en_status
);
  logic [N_CH-1:0] req_vec;
  logic [N_CH-1:0] pend;
  logic [N_CH-1:0] clr;

  assign req_vec = {req_b, req_a};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    irq_channel u_ch (
      .clk      (clk),
      .rst      (rst),
      .en_we    (en_wr),
      .en_d     (en_wdata[ch]),
      .req_in   (req_vec[ch]),
      .take_clr (clr[ch]),
      .enable   (en_status[ch]),
      .pending  (pend[ch])
    );
  end

  irq_grant #(.VEC_W(VEC_W)) u_grant (
    .clk       (clk),
    .rst       (rst),
    .grant_in  (grant_in),
    .pend      (pend),
    .jumper    (vec_jumper),
    .take_clr  (clr),
    .grant_out (grant_out),
    .vec_reply (vec_reply),
    .vec_out   (vec_out)
  );

  assign bus_req = |pend;
endmodule

// File: rtl/irq_chain_requester_chk.sv
module irq_chain_requester_chk #(
  parameter int VEC_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             en_wr,
  input logic [1:0]       en_wdata,
  input logic             grant_in,
  input logic             bus_req,
  input logic             grant_out,
  input logic             vec_reply,
  input logic [VEC_W-1:0] vec_out,
  input logic [1:0]       en_status,
  input logic [1:0]       pend
);
  assert_never_both_R4: assert property (@(posedge clk) disable iff (rst)
    !(vec_reply && grant_out));

  assert_pass_only_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_out) |-> ($past(grant_in) && !$past(bus_req)));

  assert_vec_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !vec_reply |-> (vec_out == '0));

  assert_cancel_a_R9: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !en_wdata[0]) |=> !pend[0]);

  assert_cancel_b_R9: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !en_wdata[1]) |=> !pend[1]);

  assert_take_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_reply) |-> $past(bus_req));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (en_status == 2'b00 && !bus_req && !vec_reply && !grant_out));
endmodule

bind irq_chain_requester irq_chain_requester_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_wr     (en_wr),
  .en_wdata  (en_wdata),
  .grant_in  (grant_in),
  .bus_req   (bus_req),
  .grant_out (grant_out),
  .vec_reply (vec_reply),
  .vec_out   (vec_out),
  .en_status (en_status),
  .pend      (pend)
);

// File: tb/tb_irq_chain_requester.sv
`timescale 1ns/1ps
module tb_irq_chain_requester;
  localparam int VEC_W = 9;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 1'b0;
  logic [1:0] en_wdata = 2'b00;
  logic req_a = 1'b0, req_b = 1'b0;
  logic [VEC_W-4:0] vec_jumper = 6'o12;
  logic grant_in = 1'b0;
  logic bus_req, grant_out, vec_reply;
  logic [VEC_W-1:0] vec_out;
  logic [1:0] en_status;

  int checks = 0;
  int errors = 0;
  logic [VEC_W-1:0] exp_q[$];
  logic reply_prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_requester #(.VEC_W(VEC_W)) dut (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .req_a(req_a), .req_b(req_b), .vec_jumper(vec_jumper),
    .grant_in(grant_in), .bus_req(bus_req), .grant_out(grant_out),
    .vec_reply(vec_reply), .vec_out(vec_out), .en_status(en_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_en(input logic [1:0] v);
    en_wr = 1'b1; en_wdata = v; step(); en_wr = 1'b0;
  endtask

  // driver: announce the vector expected on the next reply, then grant
  task automatic grant_expect(input logic [VEC_W-1:0] v);
    exp_q.push_back(v);
    grant_in = 1'b1; step();
  endtask

  // monitor: on each new reply, pop and compare the vector (R8, R4)
  always @(negedge clk) begin
    if (!rst && vec_reply && !reply_prev) begin
      if (exp_q.size() == 0) chk("R4 unexpected reply", 1, 0);
      else chk("R8 vector", int'(vec_out), int'(exp_q.pop_front()));
    end
    reply_prev <= vec_reply;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R7 bus_req", bus_req, 0);
    chk("R7 en_status", en_status, 0);
    chk("R7 vec_out", vec_out, 0);
    chk("R7 grant_out", grant_out, 0);
    rst = 1'b0; step();

    req_a = 1'b1; step();
    chk("R1 disabled edge", bus_req, 0);
    req_a = 1'b0; step();

    write_en(2'b11);
    chk("R6 en_status", en_status, 3);

    req_a = 1'b1; step();
    chk("R2 edge sets", bus_req, 1);
    req_a = 1'b0; step(); step();
    chk("R10 held", bus_req, 1);

    grant_expect(9'o120);
    chk("R4 reply", vec_reply, 1);
    chk("R4 grant_out", grant_out, 0);
    chk("R10 drop", bus_req, 0);
    grant_in = 1'b0; step();
    chk("R8 quiet reply", vec_reply, 0);
    chk("R8 quiet vec", vec_out, 0);

    grant_in = 1'b1; step();
    chk("R5 pass", grant_out, 1);
    chk("R5 no reply", vec_reply, 0);
    grant_in = 1'b0; step();
    chk("R5 release", grant_out, 0);

    req_a = 1'b1; req_b = 1'b1; step();
    grant_expect(9'o120);
    chk("R3 B still pending", bus_req, 1);
    grant_in = 1'b0; step();
    grant_expect(9'o124);
    chk("R10 all served", bus_req, 0);
    grant_in = 1'b0; req_a = 1'b0; req_b = 1'b0; step();

    write_en(2'b01);
    req_b = 1'b1; step();
    chk("R1 B disabled", bus_req, 0);
    write_en(2'b11); step();
    chk("R2 level ignored", bus_req, 0);
    req_b = 1'b0; step();

    req_b = 1'b1; step();
    chk("R2 B edge", bus_req, 1);
    req_b = 1'b0;
    write_en(2'b01);
    chk("R9 cancel", bus_req, 0);
    chk("R6 en_status", en_status, 1);
    grant_in = 1'b1; step();
    chk("R9 grant passed", grant_out, 1);
    grant_in = 1'b0; step();

    req_a = 1'b1; step();
    chk("R2 A edge", bus_req, 1);
    rst = 1'b1; step();
    rst = 1'b0;
    chk("R7 mid reset req", bus_req, 0);
    chk("R7 mid reset en", en_status, 0);
    req_a = 1'b0; step(); step();

    chk("R4 all replies seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule